// File: doc/BRIEF.md
# I2S Slave Sample Capture with Selectable Word Length

This block receives a two-channel serial audio stream as a slave. It does not generate the bit clock or the word-select line. Both arrive from outside, together with two candidate data lines (a main line and an auxiliary line) and a serial invalid marker. The bit clock, word select and serial inputs are oversampled in the block's own clock domain. Bits are taken on each rising bit-clock edge and assembled most-significant-bit first into a 24-bit, left-aligned word.

A configuration input chooses how many bits are significant: 16, 18, 20 or 24. Bits past that length, and bits the slot never supplied, read as zero. The invalid marker is sampled on the same edges as the data and is folded into a per-sample flag. That flag is forced clear whenever the auxiliary line is the source, because that line normally carries a converter that has no such marker. Each completed channel comes out as one record with a one-cycle strobe, at the word-select transition that closes its slot. The bit clock and word select are inputs only, and the block never drives them.

Top module: `i2s_slave_capture`

## Requirements
- R1: `len_sel` selects the significant length: 2'b00 = 16 bits, 2'b01 = 18, 2'b10 = 20, 2'b11 = 24. The first data bit of a slot lands in `smp_data[23]`, and each following bit lands one position lower.
- R2: In a strobed word, every position below the selected length is 0. This covers data bits beyond the selected length or beyond bit 24 of a long slot, which are discarded, and positions the slot did not supply.
- R3: Bits are sampled on rising edges of `sck_in`. The first bit of a slot is the one at the second rising edge at which the new `ws_in` level is seen. The last bit of a slot is the one sampled at the edge where the opposite `ws_in` level is first seen.
- R4: With `src_sel` = 1 the data comes from `sd_main`. With `src_sel` = 0 it comes from `sd_aux`.
- R5: With `src_sel` = 1, `smp_inv` is the OR of `inv_in` sampled at the same edges as the captured data bits, counting only bits within the selected length.
- R6: With `src_sel` = 0, `smp_inv` is 0 whatever `inv_in` does.
- R7: `smp_vld` is high for exactly one clock cycle per completed slot. It rises three `clk` cycles after the closing `sck_in` rising edge appears at the port (default two-stage synchronizer). `smp_right` is the `ws_in` level of the finished slot: 0 for left, 1 for right.
- R8: After reset, `smp_data`, `smp_right`, `smp_inv` and `smp_vld` are 0. The slot in progress when capture starts is discarded, so no strobe appears before one full slot bounded by two `ws_in` transitions.
- R9: `smp_data`, `smp_right` and `smp_inv` change only in the cycle in which `smp_vld` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock used to oversample the serial inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_in | input | 1 | Externally supplied serial bit clock |
| ws_in | input | 1 | Externally supplied word select, low = left |
| sd_main | input | 1 | Main serial data line |
| sd_aux | input | 1 | Auxiliary serial data line |
| inv_in | input | 1 | Serial invalid marker, aligned with the data bits |
| src_sel | input | 1 | 1 = main line, 0 = auxiliary line |
| len_sel | input | 2 | Significant length code (see R1) |
| smp_data | output | 24 | Captured left-aligned sample |
| smp_right | output | 1 | Channel of the sample, 1 = right |
| smp_inv | output | 1 | Invalid flag of the sample |
| smp_vld | output | 1 | One-cycle strobe for a new sample |

## Verification
A bit counter that drifts by one shows up at the ports on the very next strobe. The word appears shifted by one place, or a valid bit appears below the selected length. A lost word-select history shows as a strobe missing or out of place, or as the wrong `smp_right`, at the first slot boundary after the fault. An invalid accumulator that is not cleared between slots makes `smp_inv` stick high on the next sample. The reference model in the bench predicts the exact strobe cycle and the full record for each slot, so every one of these faults is seen within one slot of where it arises.

// File: rtl/i2s_cap_pkg.sv
// Package: shared constants, types and length decoding for the I2S capture block.
// Assumes a fixed 24-bit output word; the length code is two bits.
package i2s_cap_pkg;

    localparam int WORD_W = 24;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        LEN_16 = 2'b00,
        LEN_18 = 2'b01,
        LEN_20 = 2'b10,
        LEN_24 = 2'b11
    } len_code_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              right;
        logic              inv;
    } sample_rec_t;

    // Number of significant bits for a length code.
    function automatic logic [CNT_W-1:0] len_bits(input logic [1:0] code);
        case (code)
            LEN_16:  len_bits = CNT_W'(16);
            LEN_18:  len_bits = CNT_W'(18);
            LEN_20:  len_bits = CNT_W'(20);
            default: len_bits = CNT_W'(24);
        endcase
    endfunction

    // Positions that must read zero for a length code.
    function automatic logic [WORD_W-1:0] tail_mask(input logic [1:0] code);
        case (code)
            LEN_16:  tail_mask = 24'h0000FF;
            LEN_18:  tail_mask = 24'h00003F;
            LEN_20:  tail_mask = 24'h00000F;
            default: tail_mask = 24'h000000;
        endcase
    endfunction

endpackage

// File: rtl/i2s_cap_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous serial inputs.
// Assumes every bit of the bundle may change at any time; all bits see the same
// delay so that values sampled together stay aligned with each other.
module i2s_cap_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    logic [STAGES-1:0][W-1:0] chain;

    // Shift the bundle through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q_out = chain[STAGES-1];

endmodule

// File: rtl/i2s_cap_edge.sv
// Module: rising-edge detector for the synchronized bit clock.
// Assumes the bit clock is already synchronized and its high and low phases
// each last at least one block clock cycle.
module i2s_cap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    output logic rise
);

    logic sck_q;

    // Remember the previous level of the bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    assign rise = sck_s & ~sck_q;

endmodule

// File: rtl/i2s_cap_slot.sv
// Module: slot assembler. It places serial bits MSB first into a left-aligned
// word, truncates to the selected length, accumulates the invalid marker and
// emits one record at each word-select transition that closes a slot.
// Assumes bit_in, inv_bit and ws are valid in cycles where rise is high.
module i2s_cap_slot
    import i2s_cap_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rise,
    input  logic        ws,
    input  logic        bit_in,
    input  logic        inv_bit,
    input  logic [1:0]  len_sel,
    output sample_rec_t rec,
    output logic        rec_vld
);

    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(W);

    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     acc;
    logic             inv_acc;
    logic             ws_q;
    logic             seen;
    logic             aligned;

    logic             take;
    logic [W-1:0]     nxt_word;
    logic             nxt_inv;
    logic             ws_edge;

    // Work out the word and flag as they stand with the current bit included.
    always_comb begin
        take     = (cnt < len_bits(len_sel));
        nxt_word = acc | ((take && bit_in) ? (TOP_BIT >> cnt) : '0);
        nxt_inv  = inv_acc | (take & inv_bit);
        ws_edge  = seen && (ws != ws_q);
    end

    // Per-edge capture, slot closing and record emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            acc     <= '0;
            inv_acc <= 1'b0;
            ws_q    <= 1'b0;
            seen    <= 1'b0;
            aligned <= 1'b0;
            rec     <= '0;
            rec_vld <= 1'b0;
        end else begin
            rec_vld <= 1'b0;
            if (rise) begin
                ws_q <= ws;
                seen <= 1'b1;
                if (ws_edge) begin
                    aligned <= 1'b1;
                    cnt     <= '0;
                    acc     <= '0;
                    inv_acc <= 1'b0;
                    if (aligned) begin
                        rec.data  <= nxt_word;
                        rec.right <= ws_q;
                        rec.inv   <= nxt_inv;
                        rec_vld   <= 1'b1;
                    end
                end else begin
                    acc     <= nxt_word;
                    inv_acc <= nxt_inv;
                    if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/i2s_slave_capture.sv
// Module: top of the I2S slave capture block. It synchronizes the external
// serial inputs, detects bit-clock rising edges, selects the data source and
// hands bits to the slot assembler. Bit clock and word select are inputs only.
// Assumes the bit clock runs at most a quarter of the block clock rate.
module i2s_slave_capture
    import i2s_cap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_in,
    input  logic              ws_in,
    input  logic              sd_main,
    input  logic              sd_aux,
    input  logic              inv_in,
    input  logic              src_sel,
    input  logic [1:0]        len_sel,
    output logic [WORD_W-1:0] smp_data,
    output logic              smp_right,
    output logic              smp_inv,
    output logic              smp_vld
);

    localparam int BUNDLE_W = 5;

    logic [BUNDLE_W-1:0] raw_bus;
    logic [BUNDLE_W-1:0] sync_bus;
    logic                sck_s, ws_s, main_s, aux_s, inv_s;
    logic                bit_rise;
    logic                sel_bit;
    logic                sel_inv;
    sample_rec_t         rec;

    assign raw_bus = {sck_in, ws_in, sd_main, sd_aux, inv_in};

    i2s_cap_sync #(.W(BUNDLE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_bus),
        .q_out (sync_bus)
    );

    assign {sck_s, ws_s, main_s, aux_s, inv_s} = sync_bus;

    i2s_cap_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sck_s (sck_s),
        .rise  (bit_rise)
    );

    // Source choice: main line with its marker, or auxiliary line always valid.
    always_comb begin
        sel_bit = src_sel ? main_s : aux_s;
        sel_inv = src_sel & inv_s;
    end

    i2s_cap_slot #(.W(WORD_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (bit_rise),
        .ws      (ws_s),
        .bit_in  (sel_bit),
        .inv_bit (sel_inv),
        .len_sel (len_sel),
        .rec     (rec),
        .rec_vld (smp_vld)
    );

    assign smp_data  = rec.data;
    assign smp_right = rec.right;
    assign smp_inv   = rec.inv;

endmodule

// File: rtl/i2s_slave_capture_chk.sv
// Module: property checker bound to the capture top. It watches the output
// record, the configuration inputs and the internal edge strobe.
module i2s_slave_capture_chk
    import i2s_cap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              smp_vld,
    input logic [WORD_W-1:0] smp_data,
    input logic              smp_right,
    input logic              smp_inv,
    input logic              src_sel,
    input logic [1:0]        len_sel,
    input logic              bit_rise
);

    // R7: the strobe never lasts two cycles.
    a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> !smp_vld);

    // R9: the record holds while no strobe is shown.
    a_r9_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |-> ($stable(smp_data) && $stable(smp_right) && $stable(smp_inv)));

    // R6: the auxiliary source never reports an invalid sample.
    a_r6_aux_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !$past(src_sel)) |-> !smp_inv);

    // R2: positions below the selected length are zero.
    a_r2_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |-> ((smp_data & tail_mask($past(len_sel))) == '0));

    // R3: a record only follows a detected bit-clock rising edge.
    a_r3_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |-> $past(bit_rise));

endmodule

bind i2s_slave_capture i2s_slave_capture_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .smp_data  (smp_data),
    .smp_right (smp_right),
    .smp_inv   (smp_inv),
    .src_sel   (src_sel),
    .len_sel   (len_sel),
    .bit_rise  (bit_rise)
);

// File: tb/i2s_slave_capture_tb.sv
// Bench: behavioural reference built from the requirements, compared on every clock.
module i2s_slave_capture_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck_in = 1'b0, ws_in = 1'b1, sd_main = 1'b0, sd_aux = 1'b0, inv_in = 1'b0;
    logic        src_sel = 1'b1;
    logic [1:0]  len_sel = 2'b11;
    logic [23:0] smp_data;
    logic        smp_right, smp_inv, smp_vld;

    int          cyc = 0;
    int          checks = 0;
    int          failures = 0;
    bit          mon_on = 1'b0;
    bit          pre_phase = 1'b1;
    bit          done = 1'b0;
    bit          cur_ws = 1'b0;

    int          q_cyc[$];
    logic [23:0] q_dat[$];
    bit          q_right[$];
    bit          q_inv[$];
    string       q_tag[$];
    logic [23:0] held_dat = '0;
    bit          held_right = 1'b0;
    bit          held_inv = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    i2s_slave_capture u_dut (
        .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .ws_in(ws_in),
        .sd_main(sd_main), .sd_aux(sd_aux), .inv_in(inv_in),
        .src_sel(src_sel), .len_sel(len_sel),
        .smp_data(smp_data), .smp_right(smp_right), .smp_inv(smp_inv), .smp_vld(smp_vld)
    );

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", what, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Per-clock comparison against the predicted strobes.
    always @(negedge clk) begin
        if (mon_on) begin
            if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
                check(smp_vld == 1'b1, "R7 strobe missing", 32'(smp_vld), 1);
                check(smp_data == q_dat[0], {q_tag[0], " data"}, 32'(smp_data), 32'(q_dat[0]));
                check(smp_right == q_right[0], "R7 channel", 32'(smp_right), 32'(q_right[0]));
                check(smp_inv == q_inv[0], {q_tag[0], " invalid flag"}, 32'(smp_inv), 32'(q_inv[0]));
                held_dat   = q_dat[0];
                held_right = q_right[0];
                held_inv   = q_inv[0];
                void'(q_cyc.pop_front()); void'(q_dat.pop_front());
                void'(q_right.pop_front()); void'(q_inv.pop_front()); void'(q_tag.pop_front());
            end else begin
                check(smp_vld == 1'b0, pre_phase ? "R8 strobe before alignment" : "R7 unexpected strobe",
                      32'(smp_vld), 0);
                check(smp_data == held_dat && smp_right == held_right && smp_inv == held_inv,
                      "R9 record changed without strobe", 32'(smp_data), 32'(held_dat));
            end
        end
    end

    // One bit-clock period: set lines with clock low, then raise the clock.
    task automatic send_bit(input bit w, input bit bm, input bit ba, input bit iv, output int rise_cyc);
        @(negedge clk);
        sck_in = 1'b0; ws_in = w; sd_main = bm; sd_aux = ba; inv_in = iv;
        repeat (3) @(negedge clk);
        sck_in = 1'b1;
        rise_cyc = cyc;
        repeat (3) @(negedge clk);
    endtask

    // One slot of n bits; bits are taken MSB first from bit 31 of each pattern.
    task automatic send_slot(input int n, input logic [1:0] lc, input bit src,
                             input logic [31:0] mb, input logic [31:0] ab,
                             input logic [31:0] ib, input string tag);
        int          len;
        int          k;
        int          rc;
        logic [23:0] exp_d;
        bit          exp_i;
        len = (lc == 2'b00) ? 16 : (lc == 2'b01) ? 18 : (lc == 2'b10) ? 20 : 24;
        k = (n < len) ? n : len;
        exp_d = '0;
        exp_i = 1'b0;
        for (int i = 0; i < k; i++) begin
            exp_d[23-i] = src ? mb[31-i] : ab[31-i];
            if (src) exp_i = exp_i | ib[31-i];
        end
        len_sel = lc;
        src_sel = src;
        for (int i = 0; i < n; i++) begin
            send_bit((i == n-1) ? ~cur_ws : cur_ws, mb[31-i], ab[31-i], ib[31-i], rc);
            if (i == n-1) begin
                q_cyc.push_back(rc + 3); q_dat.push_back(exp_d);
                q_right.push_back(cur_ws); q_inv.push_back(exp_i); q_tag.push_back(tag);
            end
        end
        cur_ws = ~cur_ws;
    endtask

    initial begin
        int rc;
        repeat (4) @(negedge clk);
        // R8: reset values at the ports.
        check(smp_vld == 0 && smp_data == 0 && smp_right == 0 && smp_inv == 0,
              "R8 reset outputs", 32'(smp_data), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        // R8: partial slot before the first transition is discarded.
        send_bit(1'b1, 1'b1, 1'b1, 1'b1, rc);
        send_bit(1'b1, 1'b1, 1'b0, 1'b1, rc);
        send_bit(1'b0, 1'b1, 1'b1, 1'b1, rc);
        repeat (4) @(negedge clk);
        pre_phase = 1'b0;
        cur_ws = 1'b0;
        // R1 R3 R4: 16-bit length, main source, left then right.
        send_slot(16, 2'b00, 1'b1, 32'hA5C3_0000, 32'h0, 32'h0, "R1 R3 R4 len16 left");
        send_slot(16, 2'b00, 1'b1, 32'h8001_0000, 32'hFFFF_FFFF, 32'h1000_0000, "R5 R3 len16 right inv");
        // R2 R5: 18 bits kept of 24, marker only beyond the length.
        send_slot(24, 2'b01, 1'b1, 32'hFFFF_FF00, 32'h0, 32'h0000_0800, "R2 R5 len18");
        // R2 R1: 20 bits kept of 24.
        send_slot(24, 2'b10, 1'b1, 32'h1234_5F00, 32'h0, 32'h0, "R2 R1 len20");
        // R2: 24 bits kept of a 32-bit slot; trailing ones ignored.
        send_slot(32, 2'b11, 1'b1, 32'h9ABC_DEFF, 32'h0, 32'h0000_0001, "R2 R5 len24 long slot");
        // R2: 24-bit length with only 16 bits supplied.
        send_slot(16, 2'b11, 1'b1, 32'hFFFF_0000, 32'h0, 32'h0, "R2 len24 short slot");
        // R4 R6: auxiliary source, marker held high throughout.
        send_slot(24, 2'b11, 1'b0, 32'hFFFF_FFFF, 32'h5A5A_5A00, 32'hFFFF_FFFF, "R4 R6 aux");
        send_slot(24, 2'b00, 1'b0, 32'h0, 32'hC3C3_C300, 32'hFFFF_FFFF, "R4 R6 aux len16");
        // R5: marker on the last kept bit of a main-source sample.
        send_slot(24, 2'b10, 1'b1, 32'h0F0F_0F00, 32'h0, 32'h0000_1000, "R5 last kept bit");
        // R1 R2 R4 R5 R6: mixed patterns.
        for (int s = 0; s < 20; s++) begin
            int unsigned pick;
            int          n;
            pick = $urandom;
            n = (pick[1:0] == 2'd0) ? 16 : (pick[1:0] == 2'd1) ? 24 : 32;
            send_slot(n, pick[3:2], pick[4], $urandom, $urandom, $urandom & 32'h0101_0101,
                      "R1 R2 R4 R5 R6 mixed");
        end
        repeat (10) @(negedge clk);
        check(q_cyc.size() == 0, "R7 strobes outstanding", 32'(q_cyc.size()), 0);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired R7 actual=running expected=finished");
            finish_run();
        end
    end

endmodule